// File: doc/BRIEF.md
# I2C Bus Master Byte Engine

This block is a single-master I2C bus engine. A local controller hands it one command at a time: generate a START (or a repeated START), generate a STOP, shift one byte out, or shift one byte in. The engine drives SCL and SDA as open-drain pull-downs and reads both lines back through a two-stage synchronizer. Every bus phase is a parameter in system-clock cycles: bus free time, start hold, stop setup, clock low and clock high. Every time the engine lets SCL go, it waits until the line is really high before it starts the high-phase count. This lets a slave stretch the clock. If the slave holds SCL low longer than a bounded number of cycles, the engine gives up, forces a STOP and reports an error.

Commands use a valid/ready handshake. `cmd_ready` is high only while the engine is idle. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. While an operation runs, `cmd_ready` stays low and the controller must hold any further command. Back-pressure therefore lasts exactly the length of the current bus operation. When an operation ends, `done` pulses for one cycle. The `error`, `ack_received` and `rdata` outputs are valid from that cycle and hold until the next command is accepted.

Between operations the engine keeps both lines pulled low, so no stray START or STOP can appear on the bus. The only exception is after a STOP, when both lines are released. A write can append a STOP. A read appends one only when it is also flagged as the final byte.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: START (`cmd_op` = 0) holds both lines released for at least T_BUF cycles. It then pulls SDA low while SCL is high, and keeps SCL high for at least T_HDSTA cycles after that SDA fall.
- R3: STOP (`cmd_op` = 1) starts with both lines low and releases SCL first. It releases SDA at least T_SUSTO cycles after SCL is high. Both lines are left released.
- R4: A write (`cmd_op` = 2) shifts `cmd_wdata` out MSB first, one bit per SCL rising edge. SDA changes only while SCL is low, so no START or STOP condition appears during the byte.
- R5: In every bit clock, SCL is low for at least T_LOW cycles and high for at least T_HIGH cycles.
- R6: On the ninth clock of a write, SDA is released and sampled. Low gives `ack_received`=1 and `error`=0. High gives `ack_received`=0 and `error`=1.
- R7: A read (`cmd_op` = 3) returns 8 SDA samples, MSB first, on `rdata`. On the ninth clock it drives SDA to 0 when `cmd_last`=0 and releases it (1) when `cmd_last`=1.
- R8: After each SCL release, the high-phase count starts only once the synchronized SCL is seen high, so a stretched clock still yields a correct byte and full high time.
- R9: If SCL stays low for T_STRETCH cycles after a release, the engine forces a STOP sequence, sets `error`=1, and finishes with both lines released.
- R10: A write with `cmd_stop`=1 ends with a STOP condition. A read ends with a STOP only when `cmd_stop`=1 and `cmd_last`=1. Otherwise no STOP is generated.
- R11: After a START, or after a byte that ends without a STOP, both `scl_oe` and `sda_oe` are 1 when `done` pulses.
- R12: `cmd_ready` is low from the cycle after acceptance until the command finishes. `done` is a one-cycle pulse in a cycle where `cmd_ready` is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_wdata | input | 8 | Byte to write |
| cmd_stop | input | 1 | Append STOP after the byte |
| cmd_last | input | 1 | Read: final byte, answer NACK |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | NACK on write, or clock-stretch timeout |
| ack_received | output | 1 | Slave acknowledged the written byte |
| rdata | output | 8 | Byte read from the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
The bench builds the engine with short phases: T_BUF=10, T_HDSTA=8, T_SUSTO=8, T_LOW=10, T_HIGH=8 and T_STRETCH=60. With these values a whole byte takes about two hundred cycles, so dozens of random reads and writes fit in one run. The stretch limit is low enough that a slave model holding SCL for 20 cycles is tolerated, while one holding it for 1000 cycles drives the timeout and forced-STOP path. T_LOW stays above the synchronizer latency, so the synchronized SCL always shows low before a release.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BUF,    // both released, bus free time
    S_SWAIT,  // SDA low, wait for SCL seen high
    S_HOLD,   // start hold
    S_LOW,    // bit: SCL low
    S_WAIT,   // bit: SCL released, wait for it
    S_HIGH,   // bit: SCL high
    S_TAIL,   // SCL low, SDA unchanged
    S_PREP,   // both low before stop
    S_SRISE,  // stop: SCL released, wait
    S_SETUP   // stop setup
  } state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= value;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R5
  tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int T_BUF     = 470,
  parameter int T_HDSTA   = 400,
  parameter int T_SUSTO   = 400,
  parameter int T_LOW     = 470,
  parameter int T_HIGH    = 400,
  parameter int T_STRETCH = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_stop,
  input  logic       cmd_last,
  output logic       done,
  output logic       error,
  output logic       ack_received,
  output logic [7:0] rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       scl_in,
  input  logic       sda_in
);
  localparam int TMAX = imax(imax(imax(T_BUF, T_HDSTA), imax(T_SUSTO, T_LOW)),
                             imax(T_HIGH, T_STRETCH));
  localparam int CW   = $clog2(TMAX + 1);

  state_e     state_q, state_d;
  op_e        op_q;
  logic [7:0] sh_q;
  logic [3:0] bit_q;
  logic       stop_q, last_q, err_q, ack_q, free_q, done_q;
  logic       scl_s, sda_s, t_exp, bitval, want_stop;
  logic [CW-1:0] ld_val;

  i2cm_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s}));

  i2cm_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(state_d != state_q),
    .value(ld_val), .expired(t_exp));

  // bit value placed on SDA for the current slot (1 = released)
  always_comb begin
    if (op_q == OP_WRITE) bitval = (bit_q == 4'd8) ? 1'b1 : sh_q[7];
    else                  bitval = (bit_q == 4'd8) ? last_q : 1'b1;
  end

  assign want_stop = stop_q && ((op_q == OP_WRITE) || (op_q == OP_READ && last_q));

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (cmd_valid) begin
                 case (op_e'(cmd_op))
                   OP_START: state_d = S_BUF;
                   OP_STOP:  state_d = S_PREP;
                   default:  state_d = S_LOW;
                 endcase
               end
      S_BUF:   if (t_exp) state_d = S_SWAIT;
      S_SWAIT: if (scl_s) state_d = S_HOLD; else if (t_exp) state_d = S_PREP;
      S_HOLD:  if (t_exp) state_d = S_IDLE;
      S_LOW:   if (t_exp) state_d = S_WAIT;
      S_WAIT:  if (scl_s) state_d = S_HIGH; else if (t_exp) state_d = S_PREP;
      S_HIGH:  if (t_exp) state_d = (bit_q == 4'd8) ? S_TAIL : S_LOW;
      S_TAIL:  state_d = want_stop ? S_PREP : S_IDLE;
      S_PREP:  if (t_exp) state_d = S_SRISE;
      S_SRISE: if (scl_s || t_exp) state_d = S_SETUP;
      S_SETUP: if (t_exp) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      S_BUF:                  ld_val = CW'(T_BUF - 1);
      S_SWAIT, S_WAIT, S_SRISE: ld_val = CW'(T_STRETCH - 1);
      S_HOLD:                 ld_val = CW'(T_HDSTA - 1);
      S_LOW, S_PREP:          ld_val = CW'(T_LOW - 1);
      S_HIGH:                 ld_val = CW'(T_HIGH - 1);
      S_SETUP:                ld_val = CW'(T_SUSTO - 1);
      default:                ld_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_START;
      sh_q    <= '0;
      bit_q   <= '0;
      stop_q  <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      ack_q   <= 1'b0;
      free_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q != S_IDLE) && (state_d == S_IDLE);
      if (state_q != S_IDLE && state_d == S_IDLE) free_q <= (state_q == S_SETUP);
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          op_q   <= op_e'(cmd_op);
          sh_q   <= cmd_wdata;
          stop_q <= cmd_stop;
          last_q <= cmd_last;
          bit_q  <= '0;
          err_q  <= 1'b0;
          ack_q  <= 1'b0;
        end
        S_WAIT: begin
          if (scl_s) begin
            if (op_q == OP_READ && bit_q != 4'd8) sh_q <= {sh_q[6:0], sda_s};
            if (op_q == OP_WRITE && bit_q == 4'd8) begin
              ack_q <= ~sda_s;
              err_q <= sda_s;
            end
          end else if (t_exp) err_q <= 1'b1;
        end
        S_SWAIT, S_SRISE: if (!scl_s && t_exp) err_q <= 1'b1;
        S_HIGH: if (t_exp && bit_q != 4'd8) begin
          bit_q <= bit_q + 4'd1;
          if (op_q == OP_WRITE) sh_q <= {sh_q[6:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  // open-drain drive: 1 pulls the line low
  always_comb begin
    case (state_q)
      S_IDLE:          begin scl_oe = ~free_q; sda_oe = ~free_q; end
      S_BUF:           begin scl_oe = 1'b0;    sda_oe = 1'b0;    end
      S_SWAIT, S_HOLD: begin scl_oe = 1'b0;    sda_oe = 1'b1;    end
      S_LOW, S_TAIL:   begin scl_oe = 1'b1;    sda_oe = ~bitval; end
      S_WAIT, S_HIGH:  begin scl_oe = 1'b0;    sda_oe = ~bitval; end
      S_PREP:          begin scl_oe = 1'b1;    sda_oe = 1'b1;    end
      default:         begin scl_oe = 1'b0;    sda_oe = 1'b1;    end
    endcase
  end

  assign cmd_ready    = (state_q == S_IDLE);
  assign done         = done_q;
  assign error        = err_q;
  assign ack_received = ack_q;
  assign rdata        = sh_q;

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !$past(done)));
  // R4
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && (op_q == OP_WRITE || op_q == OP_READ) && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));
  // R9
  timeout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !scl_s && t_exp) |=> (scl_oe && sda_oe && error));
  // R11
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(state_q) != S_SETUP) |-> (scl_oe && sda_oe));
  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(state_q) == S_SETUP) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_BUF = 10, P_HD = 8, P_SU = 8, P_LOW = 10, P_HIGH = 8, P_STR = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_stop = 1'b0, cmd_last = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       cmd_ready, done, error, ack_received, scl_oe, sda_oe;
  logic [7:0] rdata;
  logic       scl_line, sda_line, slave_low;

  // slave model configuration
  int         s_mode = 0;       // 0 idle, 1 write target, 2 read source
  logic [7:0] s_byte = 8'd0;
  bit         s_nack = 1'b0;
  int         stretch_len = 0;
  int         rel_cnt = 0;
  int         cmd_id = 0;

  // monitor state
  int seen_id = 0, rises = 0, starts = 0, stops = 0;
  logic [3:0] falls = 4'd0;
  logic [7:0] cap = 8'd0;
  logic ninth = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1, lo_valid = 1'b0, hd_pend = 1'b0;
  int hi_cnt = 0, lo_cnt = 0, min_hi = 999, min_lo = 999;
  int free_cnt = 0, last_free = 0, hd_cnt = 0, last_hd = 0, su_cnt = 0, last_su = 0;

  int n_chk = 0, n_fail = 0;

  assign scl_line = !scl_oe && (rel_cnt >= stretch_len);
  assign sda_line = !sda_oe && !slave_low;

  always_comb begin
    slave_low = 1'b0;
    if (s_mode == 2 && falls < 4'd8) slave_low = !s_byte[3'd7 - falls[2:0]];
    if (s_mode == 1 && falls == 4'd8) slave_low = !s_nack;
  end

  i2c_byte_master #(
    .T_BUF(P_BUF), .T_HDSTA(P_HD), .T_SUSTO(P_SU),
    .T_LOW(P_LOW), .T_HIGH(P_HIGH), .T_STRETCH(P_STR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_stop(cmd_stop), .cmd_last(cmd_last),
    .done(done), .error(error), .ack_received(ack_received), .rdata(rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_line), .sda_in(sda_line));

  // bus monitor and clock-stretch model, sampled on the falling edge
  always @(negedge clk) begin
    if (seen_id != cmd_id) begin
      seen_id = cmd_id; rises = 0; falls = 4'd0; starts = 0; stops = 0;
      min_hi = 999; min_lo = 999; lo_valid = 1'b0; hd_pend = 1'b0;
      last_hd = 0; last_su = 0; last_free = 0;
    end
    if (scl_line && !prev_scl) begin
      rises = rises + 1;
      if (rises <= 8) cap = {cap[6:0], sda_line};
      if (rises == 9) ninth = sda_line;
      if (lo_valid && lo_cnt < min_lo) min_lo = lo_cnt;
      hi_cnt = 0; su_cnt = 0;
    end
    if (!scl_line && prev_scl) begin
      if (falls != 4'hf) falls = falls + 4'd1;
      if (hi_cnt < min_hi) min_hi = hi_cnt;
      lo_valid = 1'b1; lo_cnt = 0;
      if (hd_pend) begin last_hd = hd_cnt; hd_pend = 1'b0; end
    end
    if (scl_line && prev_scl && !sda_line && prev_sda) begin
      starts = starts + 1; last_free = free_cnt; hd_pend = 1'b1; hd_cnt = 0;
    end
    if (scl_line && prev_scl && sda_line && !prev_sda) begin
      stops = stops + 1; last_su = su_cnt;
    end
    if (scl_line) hi_cnt = hi_cnt + 1; else lo_cnt = lo_cnt + 1;
    hd_cnt = hd_cnt + 1; su_cnt = su_cnt + 1;
    free_cnt = (scl_line && sda_line) ? free_cnt + 1 : 0;
    prev_scl = scl_line; prev_sda = sda_line;
    rel_cnt = scl_oe ? 0 : rel_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_stop(input logic [1:0] op, input bit s, input bit l);
    if (op == 2'd2) return s;
    if (op == 2'd3) return s && l;
    return op == 2'd1;
  endfunction

  logic       r_err, r_ack;
  logic [7:0] r_rd;

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input bit stp,
                         input bit lst, input bit nack);
    bit got;
    @(negedge clk); #1;
    s_mode = (op == 2'd2) ? 1 : (op == 2'd3) ? 2 : 0;
    s_byte = d; s_nack = nack; cmd_id++;
    cmd_op = op; cmd_wdata = d; cmd_stop = stp; cmd_last = lst; cmd_valid = 1'b1;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1'b0, "R12", "ready while busy", cmd_ready, 0);
    got = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check(got, "R12", "done pulse seen", got, 1);
    check(cmd_ready == 1'b1, "R12", "ready with done", cmd_ready, 1);
    r_err = error; r_ack = ack_received; r_rd = rdata;
    @(negedge clk); #1;
  endtask

  task automatic check_byte(input logic [1:0] op, input logic [7:0] d, input bit stp,
                            input bit lst, input bit nack);
    bit es;
    es = exp_stop(op, stp, lst);
    check(starts == 0, "R4", "start inside byte", starts, 0);
    check(stops == int'(es), "R10", "stop count", stops, int'(es));
    check(min_lo >= P_LOW, "R5", "scl low time", min_lo, P_LOW);
    check(min_hi >= P_HIGH, "R5", "scl high time", min_hi, P_HIGH);
    if (op == 2'd2) begin
      check(cap == d, "R4", "written byte", cap, d);
      check(r_err == nack, "R6", "error", r_err, nack);
      check(r_ack == !nack, "R6", "ack_received", r_ack, !nack);
    end else begin
      check(r_rd == d, "R7", "read byte", r_rd, d);
      check(ninth == lst, "R7", "ninth bit", ninth, lst);
      check(r_err == 1'b0, "R7", "read error", r_err, 0);
    end
    if (es) begin
      check(last_su >= P_SU, "R3", "stop setup", last_su, P_SU);
      check(!scl_oe && !sda_oe, "R3", "released after stop", {scl_oe, sda_oe}, 0);
    end else
      check(scl_oe && sda_oe, "R11", "parked after byte", {scl_oe, sda_oe}, 3);
  endtask

  task automatic do_start;
    run_cmd(2'd0, 8'd0, 1'b0, 1'b0, 1'b0);
    check(starts == 1, "R2", "start count", starts, 1);
    check(stops == 0, "R2", "no stop in start", stops, 0);
    check(last_free >= P_BUF, "R2", "bus free time", last_free, P_BUF);
    check(last_hd >= P_HD, "R2", "start hold", last_hd, P_HD);
    check(scl_oe && sda_oe, "R11", "parked after start", {scl_oe, sda_oe}, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit released;
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "ready at reset", cmd_ready, 1);
    check(done == 1'b0, "R1", "done at reset", done, 0);
    check(!scl_oe && !sda_oe, "R1", "lines at reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_start();
    // repeated start from a parked bus
    do_start();
    released = 1'b0;

    for (int it = 0; it < 40; it++) begin
      logic [1:0] op;
      logic [7:0] d;
      bit stp, lst, nk;
      op  = ($urandom % 2) ? 2'd3 : 2'd2;
      d   = 8'($urandom);
      stp = ($urandom % 3) == 0;
      lst = ($urandom % 2) == 1;
      nk  = (op == 2'd2) && (($urandom % 4) == 0);
      if (released) do_start();
      run_cmd(op, d, stp, lst, nk);
      check_byte(op, d, stp, lst, nk);
      released = exp_stop(op, stp, lst);
    end
    if (released) do_start();

    // R10 directed: stop flag without last, last without stop
    run_cmd(2'd3, 8'h3C, 1'b1, 1'b0, 1'b0);
    check_byte(2'd3, 8'h3C, 1'b1, 1'b0, 1'b0);
    run_cmd(2'd3, 8'hC3, 1'b0, 1'b1, 1'b0);
    check_byte(2'd3, 8'hC3, 1'b0, 1'b1, 1'b0);
    // R6 boundary patterns
    run_cmd(2'd2, 8'h00, 1'b0, 1'b0, 1'b1);
    check_byte(2'd2, 8'h00, 1'b0, 1'b0, 1'b1);
    run_cmd(2'd2, 8'hFF, 1'b0, 1'b0, 1'b0);
    check_byte(2'd2, 8'hFF, 1'b0, 1'b0, 1'b0);

    // R8: tolerated stretch
    stretch_len = 20;
    run_cmd(2'd2, 8'hA5, 1'b0, 1'b0, 1'b0);
    check_byte(2'd2, 8'hA5, 1'b0, 1'b0, 1'b0);
    check(min_hi >= P_HIGH, "R8", "high time after stretch", min_hi, P_HIGH);
    run_cmd(2'd3, 8'h5A, 1'b0, 1'b0, 1'b0);
    check(r_rd == 8'h5A, "R8", "read under stretch", r_rd, 8'h5A);

    // R9: stretch beyond the limit
    stretch_len = 1000;
    run_cmd(2'd2, 8'h96, 1'b0, 1'b0, 1'b0);
    check(r_err == 1'b1, "R9", "timeout error", r_err, 1);
    check(!scl_oe && !sda_oe, "R9", "released after timeout", {scl_oe, sda_oe}, 0);
    stretch_len = 0;
    repeat (5) @(negedge clk);

    // R3: explicit stop command
    do_start();
    run_cmd(2'd1, 8'd0, 1'b0, 1'b0, 1'b0);
    check(stops == 1, "R3", "stop command", stops, 1);
    check(last_su >= P_SU, "R3", "stop setup", last_su, P_SU);
    check(!scl_oe && !sda_oe, "R3", "released after stop cmd", {scl_oe, sda_oe}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule